// File: doc/BRIEF.md
# PLL Configuration and Lock Status Controller

This block holds the runtime settings of a system clock PLL (input divider, feedback multiplier and output divider) and reports when the PLL output can be trusted. On every reset it copies all three settings from a non-volatile configuration word. It then drives them onto the analog PLL's control pins. Software reaches the settings through a plain register write port and a read port that is always valid. Software may retune the multiplier and the output divider. The input divider is frozen at its reset value, so the PLL input frequency cannot be pushed out of range at run time.

Each time the PLL input conditions change, the lock status bit drops to 0 and a start-up timer starts from its full count. A change is a reset, or a write that alters the multiplier or the output divider. The status bit rises when the PLL's lock indication arrives or when the timer runs out, whichever comes first. It rises at expiry even if lock never came. The lock input must be synchronous to `clk`. Control and status pins are plain levels; there is no streaming data path and so no valid/ready handshake.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller loads the input divider from `cfg_word[2:0]`, the multiplier from `cfg_word[10:8]` and the output divider from `cfg_word[18:16]`. These values appear on `pll_idiv`, `pll_mul`, `pll_odiv` and in the same bit positions of `rd_data`.
- R2: After reset, a write never changes the input divider. Both `pll_idiv` and `rd_data[2:0]` keep the value loaded at reset.
- R3: A write (`wr_en` high at a rising edge) updates the multiplier from `wr_data[10:8]` and the output divider from `wr_data[18:16]`. The new values show on the outputs after that edge.
- R4: A reset edge, or a write edge where `wr_data[10:8]` or `wr_data[18:16]` differs from the current setting, clears the lock status (`lock_status` and `rd_data[5]`) to 0 and restarts the start-up timer.
- R5: While the status is 0 and no restart happens, `pll_lock` high at a rising edge sets the status to 1 at that edge.
- R6: With `pll_lock` held low, the status becomes 1 at exactly the TMR_CYCLES-th rising edge after the restart edge. It is still 0 one edge earlier.
- R7: A write that leaves both the multiplier and the output divider unchanged does not clear the status and does not move the pending expiry.
- R8: A settings change during an ongoing lock wait restarts the full TMR_CYCLES window from the edge of that change.
- R9: `rd_data` carries the status at bit 5 and reads 0 in every bit outside the three fields and bit 5. Write data in bit 5 has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads settings from `cfg_word` |
| cfg_word | input | DATA_W | Non-volatile configuration word holding the reset settings |
| wr_en | input | 1 | Register write strobe, one write per cycle high |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Current register contents |
| pll_lock | input | 1 | Lock indication from the analog PLL, synchronous to `clk` |
| pll_idiv | output | IDIV_W | Input divider setting to the PLL |
| pll_mul | output | MUL_W | Multiplier setting to the PLL |
| pll_odiv | output | ODIV_W | Output divider setting to the PLL |
| lock_status | output | 1 | Lock status, 1 once lock or timeout has occurred |

## Verification
The bench probes the exact expiry edge, checking the status one cycle before and at TMR_CYCLES. An off-by-one timer would show up there as an early or late rise. It writes a new input divider and a bit-5 value with unchanged settings; a design that let these through would show a changed divider or a dropped status. It retunes during an open wait, after a same-value write. A timer that did not restart would rise at the first window's end, and one that restarted on any write would rise late. Constrained random writes and lock pulses are compared cycle by cycle with a bench model, and a second reset with a new configuration word checks the reload.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  // Register bit positions; the status bit position is visible to software.
  localparam int IDIV_LSB = 0;
  localparam int STAT_BIT = 5;
  localparam int MUL_LSB  = 8;
  localparam int ODIV_LSB = 16;

  typedef enum logic {
    LK_HELD = 1'b0,
    LK_WAIT = 1'b1
  } lock_state_e;
endpackage

// File: rtl/pll_cfg_fields.sv
module pll_cfg_fields #(
  parameter int IDIV_W = 3,
  parameter int MUL_W  = 3,
  parameter int ODIV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDIV_W-1:0] cfg_idiv,
  input  logic [MUL_W-1:0]  cfg_mul,
  input  logic [ODIV_W-1:0] cfg_odiv,
  input  logic              wr_en,
  input  logic [MUL_W-1:0]  wr_mul,
  input  logic [ODIV_W-1:0] wr_odiv,
  output logic [IDIV_W-1:0] idiv,
  output logic [MUL_W-1:0]  mul,
  output logic [ODIV_W-1:0] odiv,
  output logic              settings_chg
);
  // A write only counts as a change when one of the writable fields moves.
  always_comb begin
    settings_chg = wr_en && ((wr_mul != mul) || (wr_odiv != odiv));
  end

  // The input divider is only ever loaded during reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idiv <= cfg_idiv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul  <= cfg_mul;
      odiv <= cfg_odiv;
    end else if (wr_en) begin
      mul  <= wr_mul;
      odiv <= wr_odiv;
    end
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
  import pll_cfg_pkg::*;
#(
  parameter int TMR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pll_lock,
  output logic lock_status
);
  localparam int CNT_W = (TMR_CYCLES > 2) ? $clog2(TMR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMR_CYCLES - 1);

  lock_state_e      state;
  logic [CNT_W-1:0] cnt;

  // Restart has priority; then lock or an empty counter ends the wait.
  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      state <= LK_WAIT;
      cnt   <= CNT_LOAD;
    end else if (state == LK_WAIT) begin
      if (pll_lock || (cnt == '0)) begin
        state <= LK_HELD;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign lock_status = (state == LK_HELD);
endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDIV_W     = 3,
  parameter int MUL_W      = 3,
  parameter int ODIV_W     = 3,
  parameter int TMR_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pll_lock,
  output logic [IDIV_W-1:0] pll_idiv,
  output logic [MUL_W-1:0]  pll_mul,
  output logic [ODIV_W-1:0] pll_odiv,
  output logic              lock_status
);
  logic settings_chg;
  logic unused_bits;

  assign unused_bits = ^{cfg_word, wr_data};

  pll_cfg_fields #(
    .IDIV_W(IDIV_W),
    .MUL_W (MUL_W),
    .ODIV_W(ODIV_W)
  ) u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_idiv    (cfg_word[IDIV_LSB +: IDIV_W]),
    .cfg_mul     (cfg_word[MUL_LSB +: MUL_W]),
    .cfg_odiv    (cfg_word[ODIV_LSB +: ODIV_W]),
    .wr_en       (wr_en),
    .wr_mul      (wr_data[MUL_LSB +: MUL_W]),
    .wr_odiv     (wr_data[ODIV_LSB +: ODIV_W]),
    .idiv        (pll_idiv),
    .mul         (pll_mul),
    .odiv        (pll_odiv),
    .settings_chg(settings_chg)
  );

  pll_lock_timer #(
    .TMR_CYCLES(TMR_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (settings_chg),
    .pll_lock   (pll_lock),
    .lock_status(lock_status)
  );

  always_comb begin
    rd_data                        = '0;
    rd_data[IDIV_LSB +: IDIV_W]    = pll_idiv;
    rd_data[MUL_LSB +: MUL_W]      = pll_mul;
    rd_data[ODIV_LSB +: ODIV_W]    = pll_odiv;
    rd_data[STAT_BIT]              = lock_status;
  end
endmodule

// File: rtl/pll_cfg_ctrl_chk.sv
module pll_cfg_ctrl_chk
  import pll_cfg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDIV_W     = 3,
  parameter int MUL_W      = 3,
  parameter int ODIV_W     = 3,
  parameter int TMR_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              pll_lock,
  input logic [IDIV_W-1:0] pll_idiv,
  input logic [MUL_W-1:0]  pll_mul,
  input logic [ODIV_W-1:0] pll_odiv,
  input logic              lock_status
);
  localparam int LO_W = $clog2(TMR_CYCLES + 2) + 1;

  logic            chg;
  logic            run_q;
  logic [LO_W-1:0] lo_cnt;
  logic            unused_wr;

  assign unused_wr = ^wr_data;
  assign chg = wr_en && ((wr_data[MUL_LSB +: MUL_W] != pll_mul) ||
                         (wr_data[ODIV_LSB +: ODIV_W] != pll_odiv));

  always_ff @(posedge clk) begin
    run_q <= rst_n;
    if (!rst_n || chg || lock_status) begin
      lo_cnt <= '0;
    end else begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assert_idiv_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> $stable(pll_idiv));

  assert_mul_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pll_mul == $past(wr_data[MUL_LSB +: MUL_W])));

  assert_change_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !lock_status);

  assert_lock_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_status && pll_lock && !chg) |=> lock_status);

  assert_timeout_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= LO_W'(TMR_CYCLES));

  assert_same_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_status && !chg) |=> lock_status);
endmodule

bind pll_cfg_ctrl pll_cfg_ctrl_chk #(
  .DATA_W    (DATA_W),
  .IDIV_W    (IDIV_W),
  .MUL_W     (MUL_W),
  .ODIV_W    (ODIV_W),
  .TMR_CYCLES(TMR_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .pll_lock   (pll_lock),
  .pll_idiv   (pll_idiv),
  .pll_mul    (pll_mul),
  .pll_odiv   (pll_odiv),
  .lock_status(lock_status)
);

// File: tb/tb_pll_cfg_ctrl.sv
module tb_pll_cfg_ctrl;
  localparam int T = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'hA5F2_F6FD;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pll_lock = 1'b0;
  logic [2:0]  pll_idiv, pll_mul, pll_odiv;
  logic        lock_status;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic [2:0] m_idiv, m_mul, m_odiv;
  logic       m_stat;
  int         m_rem;

  always #10 clk = ~clk;

  pll_cfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pll_lock(pll_lock),
    .pll_idiv(pll_idiv), .pll_mul(pll_mul), .pll_odiv(pll_odiv),
    .lock_status(lock_status)
  );

  function automatic logic [31:0] word(input logic [2:0] i, input logic [2:0] m,
                                       input logic [2:0] o, input logic s);
    logic [31:0] w = '0;
    w[2:0] = i; w[10:8] = m; w[18:16] = o; w[5] = s;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idiv = cfg_word[2:0]; m_mul = cfg_word[10:8]; m_odiv = cfg_word[18:16];
      m_stat = 1'b0; m_rem = T;
    end else if (wr_en && (wr_data[10:8] != m_mul || wr_data[18:16] != m_odiv)) begin
      m_mul = wr_data[10:8]; m_odiv = wr_data[18:16];
      m_stat = 1'b0; m_rem = T;
    end else if (!m_stat) begin
      if (pll_lock) m_stat = 1'b1;
      else begin
        m_rem = m_rem - 1;
        if (m_rem == 0) m_stat = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lock_pulse();
    pll_lock = 1'b1;
    @(negedge clk);
    pll_lock = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(3);
    rst_n = 1'b1;
    // R1: reset load; R4: status cleared by reset; R9: other bits zero
    check("R1 reset load", rd_data, word(3'd5, 3'd6, 3'd2, 1'b0));
    check("R1 pins", {23'd0, pll_idiv, pll_mul, pll_odiv}, {23'd0, 3'd5, 3'd6, 3'd2});
    // R6: timeout without lock
    wait_cyc(T - 1);
    check("R6 before expiry", {31'd0, lock_status}, 32'd0);
    wait_cyc(1);
    check("R6 at expiry", rd_data, word(3'd5, 3'd6, 3'd2, 1'b1));
    // R2 and R7: write new idiv, same mul/odiv
    do_write(word(3'd1, 3'd6, 3'd2, 1'b0));
    check("R2 idiv write ignored", rd_data, word(3'd5, 3'd6, 3'd2, 1'b1));
    check("R7 status kept", {31'd0, lock_status}, 32'd1);
    // R3, R4: change multiplier
    do_write(word(3'd0, 3'd3, 3'd2, 1'b1));
    check("R3 R4 mul change", rd_data, word(3'd5, 3'd3, 3'd2, 1'b0));
    check("R3 pin", {29'd0, pll_mul}, 32'd3);
    wait_cyc(5);
    check("R5 before lock", {31'd0, lock_status}, 32'd0);
    lock_pulse();
    check("R5 lock sets", {31'd0, lock_status}, 32'd1);
    // R8 with an embedded R7 same-value write and R9 bit-5 write
    do_write(word(3'd5, 3'd3, 3'd4, 1'b0));
    check("R3 odiv change", rd_data, word(3'd5, 3'd3, 3'd4, 1'b0));
    wait_cyc(4);
    do_write(32'hFFF8_FBFF & ~32'h0007_0700 | word(3'd0, 3'd3, 3'd4, 1'b1));
    check("R9 bit5 write ignored", rd_data, word(3'd5, 3'd3, 3'd4, 1'b0));
    wait_cyc(5);
    do_write(word(3'd5, 3'd7, 3'd4, 1'b0));
    wait_cyc(T - 1);
    check("R8 restarted window", {31'd0, lock_status}, 32'd0);
    wait_cyc(1);
    check("R8 expiry after restart", rd_data, word(3'd5, 3'd7, 3'd4, 1'b1));
    // random phase against model
    for (int i = 0; i < 2000; i++) begin
      wr_en    = ($urandom_range(0, 7) == 0);
      wr_data  = $urandom();
      if ($urandom_range(0, 1) == 0) begin
        wr_data[10:8] = m_mul; wr_data[18:16] = m_odiv;
      end
      pll_lock = ($urandom_range(0, 39) == 0);
      @(negedge clk);
      check("R3 R4 R5 R6 R7 random", rd_data, word(m_idiv, m_mul, m_odiv, m_stat));
    end
    wr_en = 1'b0; pll_lock = 1'b0;
    // second reset with another configuration word (R1)
    cfg_word = 32'h0003_0102;
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    check("R1 reload", rd_data, word(3'd2, 3'd1, 3'd3, 1'b0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule